// File: doc/BRIEF.md
# Leaky Bucket Activity Alarm

This block turns a stream of clock-irregularity reports into a debounced activity alarm. Two monitors, one that watches the frequency range and one that watches for missing cycles, can each pulse an event input at any time. The block groups time into fixed monitoring intervals. A built-in prescaler on the system clock marks the end of each interval. Any interval that saw at least one event adds one unit to an accumulator, which is the bucket. A programmable run of 1, 2, 4 or 8 quiet intervals removes one unit.

The alarm is set when the bucket reaches an upper threshold, and the clock is then flagged invalid. The alarm clears only when the bucket drains to a lower threshold, which gives hysteresis. The bucket stops at a programmable size. A configuration that breaks the rule size ≥ upper > lower is reported, and while it is reported the alarm keeps its state. One set of configuration inputs is shared by both event sources.

Top module: `lbk_activity_alarm`

## Requirements
- R1: `tick_o` pulses high for one cycle every TICK_CNT clock cycles. The first pulse is in cycle TICK_CNT−1 after reset is released.
- R2: On the clock edge where `tick_o` is high, the level rises by exactly one if either event input was high on any edge of that interval, including the tick edge itself. Several events in one interval still give one unit. On all other edges the level does not change.
- R3: The level never increments past `size_i`. A fill event at or above the size leaves the level unchanged.
- R4: A quiet interval advances a leak counter. When the counter reaches 2^`decay_i` intervals, the level drops by one and the counter restarts. An interval with an event restarts the counter and blocks the leak.
- R5: A leak at level zero leaves the level at zero.
- R6: One cycle after the level is at or above `upper_i` with a valid configuration, `alarm_o` is 1. `clk_invalid_o` is high whenever `alarm_o` is high.
- R7: One cycle after the level is at or below `lower_i` with a valid configuration, `alarm_o` is 0. While the level lies strictly between the two thresholds, the alarm keeps its state.
- R8: `cfg_err_o` is high exactly when `size_i` < `upper_i` or `upper_i` ≤ `lower_i`. While it is high, `alarm_o` keeps its state.
- R9: During reset the level is 0, the alarm is 0 and no tick is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_evt_i | input | 1 | Event pulse from the frequency-range monitor |
| act_evt_i | input | 1 | Event pulse from the missing-cycle monitor |
| size_i | input | ACC_W | Bucket size (level ceiling) |
| upper_i | input | ACC_W | Alarm declare threshold |
| lower_i | input | ACC_W | Alarm clear threshold |
| decay_i | input | DECAY_W | Leak exponent: leak period is 2^decay_i intervals |
| tick_o | output | 1 | Interval end strobe |
| level_o | output | ACC_W | Current bucket level |
| alarm_o | output | 1 | Activity alarm |
| clk_invalid_o | output | 1 | Monitored clock flagged invalid |
| cfg_err_o | output | 1 | Configuration breaks size ≥ upper > lower |

## Verification
A faulty event latch or leak counter does not show at once. The error appears on `level_o` at the next interval end, and only on the alarm pins one cycle after the wrong level crosses a threshold. The bench therefore keeps a behavioural model of the level and the alarm and compares both on every cycle, so a wrong level is caught within one interval. The scenarios drive the level through saturation, leak periods of 1 and 4 intervals, drains that stop at zero, events that land on the tick edge, and a configuration error held across a full drain. These are the points where a wrong counter diverges from the model.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FILL = 2'd1,
    STEP_LEAK = 2'd2
  } step_e;
endpackage

// File: rtl/lbk_prescaler.sv
module lbk_prescaler #(
  parameter int unsigned TICK_CNT = 25_600_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (TICK_CNT > 1) ? $clog2(TICK_CNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CNT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  if (TICK_CNT > 1) begin : g_gap_chk
    assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/lbk_interval_judge.sv
module lbk_interval_judge
  import lbk_pkg::*;
#(
  parameter int unsigned DECAY_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               freq_evt_i,
  input  logic               act_evt_i,
  input  logic [DECAY_W-1:0] decay_i,
  output step_e              step_o
);
  localparam int unsigned LEAK_W = 1 << DECAY_W;

  logic              seen_q;
  logic              evt_any;
  logic              hit;
  logic [LEAK_W-1:0] lcnt_q, lcnt_d;
  logic [LEAK_W:0]   period;
  logic [LEAK_W:0]   lcnt_inc;

  assign evt_any  = freq_evt_i | act_evt_i;
  assign hit      = seen_q | evt_any;
  assign period   = (LEAK_W+1)'(1) << decay_i;
  assign lcnt_inc = {1'b0, lcnt_q} + 1'b1;

  always_comb begin
    step_o = STEP_HOLD;
    lcnt_d = lcnt_q;
    if (tick_i) begin
      if (hit) begin
        step_o = STEP_FILL;
        lcnt_d = '0;
      end else if (lcnt_inc >= period) begin
        step_o = STEP_LEAK;
        lcnt_d = '0;
      end else begin
        lcnt_d = lcnt_inc[LEAK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      lcnt_q <= '0;
    end else begin
      seen_q <= tick_i ? 1'b0 : hit;
      lcnt_q <= lcnt_d;
    end
  end

  // fill restarts leak period
  assert_fill_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && evt_any) |=> (lcnt_q == '0));
  assert_step_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> (step_o == STEP_HOLD));
endmodule

// File: rtl/lbk_accum.sv
module lbk_accum
  import lbk_pkg::*;
#(
  parameter int unsigned ACC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_e            step_i,
  input  logic [ACC_W-1:0] size_i,
  output logic [ACC_W-1:0] level_o
);
  logic [ACC_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else begin
      unique case (step_i)
        STEP_FILL: if (level_q < size_i) level_q <= level_q + 1'b1;
        STEP_LEAK: if (level_q != '0) level_q <= level_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign level_o = level_q;

  assert_fill_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_FILL && level_q < size_i) |=> (level_q == $past(level_q) + 1'b1));
  assert_hold_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_HOLD) |=> $stable(level_q));
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_FILL && level_q >= size_i) |=> $stable(level_q));
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_LEAK && level_q == '0) |=> (level_q == '0));
endmodule

// File: rtl/lbk_alarm.sv
module lbk_alarm #(
  parameter int unsigned ACC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] level_i,
  input  logic [ACC_W-1:0] size_i,
  input  logic [ACC_W-1:0] upper_i,
  input  logic [ACC_W-1:0] lower_i,
  output logic             alarm_o,
  output logic             cfg_err_o
);
  logic alarm_q, alarm_d;

  assign cfg_err_o = (size_i < upper_i) || (upper_i <= lower_i);

  always_comb begin
    alarm_d = alarm_q;
    if (!cfg_err_o) begin
      if (level_i >= upper_i) alarm_d = 1'b1;
      else if (level_i <= lower_i) alarm_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else alarm_q <= alarm_d;
  end

  assign alarm_o = alarm_q;

  assert_declare_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_o && level_i >= upper_i) |=> alarm_o);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_o && level_i <= lower_i) |=> !alarm_o);
  assert_hyst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_o && level_i > lower_i && level_i < upper_i) |=> $stable(alarm_o));
  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> $stable(alarm_o));
endmodule

// File: rtl/lbk_activity_alarm.sv
module lbk_activity_alarm
  import lbk_pkg::*;
#(
  parameter int unsigned ACC_W    = 8,
  parameter int unsigned DECAY_W  = 2,
  parameter int unsigned TICK_CNT = 25_600_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               freq_evt_i,
  input  logic               act_evt_i,
  input  logic [ACC_W-1:0]   size_i,
  input  logic [ACC_W-1:0]   upper_i,
  input  logic [ACC_W-1:0]   lower_i,
  input  logic [DECAY_W-1:0] decay_i,
  output logic               tick_o,
  output logic [ACC_W-1:0]   level_o,
  output logic               alarm_o,
  output logic               clk_invalid_o,
  output logic               cfg_err_o
);
  logic  tick;
  step_e step;

  lbk_prescaler #(.TICK_CNT(TICK_CNT)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  lbk_interval_judge #(.DECAY_W(DECAY_W)) u_judge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .freq_evt_i(freq_evt_i),
    .act_evt_i (act_evt_i),
    .decay_i   (decay_i),
    .step_o    (step)
  );

  lbk_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .size_i (size_i),
    .level_o(level_o)
  );

  lbk_alarm #(.ACC_W(ACC_W)) u_alarm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level_o),
    .size_i   (size_i),
    .upper_i  (upper_i),
    .lower_i  (lower_i),
    .alarm_o  (alarm_o),
    .cfg_err_o(cfg_err_o)
  );

  assign tick_o        = tick;
  assign clk_invalid_o = alarm_o;
endmodule

// File: tb/lbk_activity_alarm_tb.sv
module lbk_activity_alarm_tb;
  localparam int TICK = 4;
  localparam int AW   = 8;
  localparam int DW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          freq_evt = 1'b0, act_evt = 1'b0;
  logic [AW-1:0] size = 8'd10, upper = 8'd8, lower = 8'd1;
  logic [DW-1:0] decay = '0;
  logic          tick_o, alarm_o, clk_invalid_o, cfg_err_o;
  logic [AW-1:0] level_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int prev_lvl, prev_alm;

  always #2.5 clk = ~clk;

  lbk_activity_alarm #(.ACC_W(AW), .DECAY_W(DW), .TICK_CNT(TICK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .freq_evt_i(freq_evt), .act_evt_i(act_evt),
    .size_i(size), .upper_i(upper), .lower_i(lower), .decay_i(decay),
    .tick_o(tick_o), .level_o(level_o), .alarm_o(alarm_o),
    .clk_invalid_o(clk_invalid_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt, m_lc, m_lvl, m_alm;
  bit m_seen;
  function automatic bit cfg_bad();
    return (int'(size) < int'(upper)) || (int'(upper) <= int'(lower));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lc = 0; m_lvl = 0; m_alm = 0; m_seen = 0;
    end else begin
      if (!cfg_bad()) begin
        if (m_lvl >= int'(upper)) m_alm = 1;
        else if (m_lvl <= int'(lower)) m_alm = 0;
      end
      if (m_cnt == TICK - 1) begin
        if (m_seen || freq_evt || act_evt) begin
          if (m_lvl < int'(size)) m_lvl++;
          m_lc = 0;
        end else begin
          m_lc++;
          if (m_lc >= (1 << int'(decay))) begin
            m_lc = 0;
            if (m_lvl > 0) m_lvl--;
          end
        end
        m_seen = 0;
        m_cnt = 0;
      end else begin
        m_seen = m_seen || freq_evt || act_evt;
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 tick", int'(tick_o), int'(m_cnt == TICK - 1));
      chk("R2 R3 R4 R5 level", int'(level_o), m_lvl);
      chk("R6 R7 alarm", int'(alarm_o), m_alm);
      chk("R6 clk_invalid", int'(clk_invalid_o), m_alm);
      chk("R8 cfg_err", int'(cfg_err_o), int'(cfg_bad()));
    end
  end

  // one interval: starts just after a tick edge, ends just after the next
  task automatic run_iv(input logic fe, input logic ae, input bit late);
    prev_lvl = int'(level_o);
    freq_evt = fe; act_evt = ae;
    @(posedge clk); #1;
    prev_alm = int'(alarm_o);
    freq_evt = 1'b0; act_evt = 1'b0;
    do @(negedge clk); while (!tick_o);
    if (late) act_evt = 1'b1;
    @(posedge clk); #1;
    act_evt = 1'b0;
  endtask

  initial begin
    #12;
    chk("R9 reset level", int'(level_o), 0);
    chk("R9 reset alarm", int'(alarm_o), 0);
    chk("R9 reset tick", int'(tick_o), 0);
    @(negedge clk); rst_n = 1'b1;
    do @(negedge clk); while (!tick_o);
    @(posedge clk); #1;

    // phase A: decay 0, fill to saturation
    for (int i = 1; i <= 12; i++) begin
      run_iv(1'b0, 1'b1, 1'b0);
      if (i == 8) begin
        chk("R6 below upper lvl", prev_lvl, 7);
        chk("R6 below upper alm", prev_alm, 0);
      end
      if (i == 9) begin
        chk("R6 declare lvl", prev_lvl, 8);
        chk("R6 declare alm", prev_alm, 1);
      end
    end
    for (int d = 1; d <= 13; d++) begin
      run_iv(1'b0, 1'b0, 1'b0);
      if (d == 1) chk("R3 saturated", prev_lvl, 10);
      if (d == 6) begin
        chk("R7 hyst lvl", prev_lvl, 5);
        chk("R7 hyst alm", prev_alm, 1);
      end
      if (d == 10) begin
        chk("R7 clear lvl", prev_lvl, 1);
        chk("R7 clear alm", prev_alm, 0);
      end
      if (d == 13) chk("R5 floor", prev_lvl, 0);
    end

    // phase B: decay 2 -> leak every 4 quiet intervals
    decay = 2'd2;
    for (int i = 0; i < 3; i++) run_iv(1'b1, 1'b0, 1'b0);
    for (int d = 1; d <= 5; d++) begin
      run_iv(1'b0, 1'b0, 1'b0);
      if (d == 1) chk("R2 freq fills", prev_lvl, 3);
      if (d == 4) chk("R4 no leak yet", prev_lvl, 3);
      if (d == 5) chk("R4 leak after 4", prev_lvl, 2);
    end
    // d=5 was the 1st quiet interval of a new period
    run_iv(1'b1, 1'b1, 1'b1);  // both sources + tick-edge event: one unit
    for (int d = 1; d <= 5; d++) begin
      run_iv(1'b0, 1'b0, 1'b0);
      if (d == 1) chk("R2 one unit per interval", prev_lvl, 3);
      if (d == 4) chk("R4 fill restarts period", prev_lvl, 3);
      if (d == 5) chk("R4 leak after restart", prev_lvl, 2);
    end
    run_iv(1'b0, 1'b0, 1'b1);  // event only on the tick edge
    run_iv(1'b0, 1'b0, 1'b0);
    chk("R2 tick-edge event", prev_lvl, 3);

    // phase C: configuration error holds the alarm
    decay = 2'd0;
    for (int i = 0; i < 6; i++) run_iv(1'b0, 1'b1, 1'b0);
    run_iv(1'b0, 1'b0, 1'b0);
    chk("R6 alarm before cfg err", prev_alm, 1);
    upper = 8'd3; lower = 8'd5;
    for (int d = 1; d <= 12; d++) run_iv(1'b0, 1'b0, 1'b0);
    chk("R8 drained lvl", prev_lvl, 0);
    chk("R8 alarm held", prev_alm, 1);
    chk("R8 cfg_err high", int'(cfg_err_o), 1);
    upper = 8'd8; lower = 8'd1;
    run_iv(1'b0, 1'b0, 1'b0);
    chk("R8 cfg_err low", int'(cfg_err_o), 0);
    chk("R7 clear after cfg fix", prev_alm, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule